// File: doc/BRIEF.md
# Boot-Time ROM Signature Scanner with Identifier Override

This block runs once after system reset is released and before the processor may start. It holds the processor in reset and drives the program ROM address bus itself. It then reads the ROM one byte at a time from address zero, looking for a seven-byte code signature. Two bytes inside that signature may take any value, and together they give the address of a pointer. The pointer, in turn, gives the location of a two-byte game identifier.

When the search ends, the block hands the address bus back to the processor. One cycle later it releases the processor reset. From then on, every processor read of the identifier location returns a configured substitute value instead of the ROM contents. If the signature is never found, the block still hands over the bus and releases reset, but it raises a not-found flag and substitutes nothing. A bypass input skips the whole search.

Each ROM read holds its address for a parameterised number of wait cycles plus one. A counter reports how many cycles were spent reading.

Top module: `boot_sig_patcher`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `cpu_rst` is 1 and `rom_addr` is 0, because the block owns the bus and the first read is at address 0.
- R2: Scan reads go to consecutive addresses, and each address is held for WAIT+1 cycles. When the block finishes, `scan_cycles` equals the number of ROM reads times WAIT+1.
- R3: The signature is the byte sequence 0xEC, 0x9F, X, Y, 0x83, 0x12, 0x34 at rising addresses. X and Y may be any value.
- R4: A mismatch partway through a candidate does not hide an occurrence that overlaps it, including one whose first byte 0xEC is the byte that broke the candidate. The first occurrence to complete is the one used.
- R5: The pointer address is (X<<8)|Y. The identifier location is (ROM[P]<<8)|ROM[P+1]. All addresses are cut to the address width and wrap at the selected image size. After a hit the block performs exactly two more reads.
- R6: At handoff the bus returns to the processor, so `rom_addr` follows `cpu_addr`, for one cycle while `cpu_rst` is still 1. Then `cpu_rst` falls, `done` rises in the same cycle, and both keep those values until the next reset.
- R7: After `done`, with `cpu_rd`=1, an address equal to the location returns `subst_id[15:8]`, and location+1 returns `subst_id[7:0]`. Every other address, and any cycle with `cpu_rd`=0, returns `rom_rdata`.
- R8: With no signature in the image, every address of the image is read once. Then `not_found`=1 and no data is substituted.
- R9: With `scan_disable`=1, no ROM reads happen (`scan_cycles`=0), `not_found`=0, and no data is substituted.
- R10: `size_sel`=1 makes the image 2^ADDR_W bytes and `size_sel`=0 makes it 2^(ADDR_W-1) bytes. A signature beyond the half-size image is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| scan_disable | input | 1 | Skip the scan and the substitution |
| size_sel | input | 1 | 1 = full image, 0 = half-size image |
| subst_id | input | 16 | Substitute identifier, high byte first |
| cpu_addr | input | ADDR_W | Processor ROM address |
| cpu_rd | input | 1 | Processor read strobe |
| rom_rdata | input | 8 | ROM read data |
| rom_addr | output | ADDR_W | ROM address (block during scan, processor after) |
| cpu_rst | output | 1 | Processor reset, high during scan |
| cpu_rdata | output | 8 | Data returned to the processor |
| done | output | 1 | Boot scan finished |
| not_found | output | 1 | Scan ended without a signature |
| scan_cycles | output | CNT_W | Cycles spent on ROM reads |

## Verification
The bench plants signatures at chosen places in a small ROM. It checks exact read-cycle totals, so a matcher that skips a byte, or a pointer walk that takes an extra read, shows up as a wrong count. One image breaks a candidate with 0xEC one byte before the end. A matcher that only returns to its idle state would miss the real occurrence that begins on that byte and would report not-found. The half-size runs place the pointer address above the half boundary and the signature beyond it. A design that ignored the size setting would read the wrong pointer, or would find a signature it should not see. At handoff the bench checks that the bus follows the processor address one cycle before reset falls, which catches a design that releases both in the same cycle.

// File: rtl/boot_scan_pkg.sv
package boot_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_PTR_HI, ST_PTR_LO, ST_HANDOFF, ST_RUN
  } scan_state_t;

  localparam logic [7:0] SIG_B0 = 8'hEC;
  localparam logic [7:0] SIG_B1 = 8'h9F;
  localparam logic [7:0] SIG_B4 = 8'h83;
  localparam logic [7:0] SIG_B5 = 8'h12;
  localparam logic [7:0] SIG_B6 = 8'h34;
endpackage

// File: rtl/rd_wait_timer.sv
module rd_wait_timer #(
  parameter int WAIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic last
);
  localparam int WW = (WAIT > 0) ? $clog2(WAIT + 1) : 1;
  localparam logic [WW-1:0] WMAX = WW'(WAIT);

  logic [WW-1:0] wcnt;

  assign last = busy && (wcnt == WMAX);

  always_ff @(posedge clk) begin
    if (rst || !busy || last) wcnt <= '0;
    else                      wcnt <= wcnt + 1'b1;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wcnt <= WMAX); // R2
endmodule

// File: rtl/sig_window.sv
module sig_window
  import boot_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        push,
  input  logic [7:0]  din,
  output logic        hit,
  output logic [15:0] ptr
);
  // the six most recent bytes; idx 5 is the oldest
  logic [7:0] win [6];

  // complete window compare: overlapping candidates are covered by construction
  assign hit = push && (win[5] == SIG_B0) && (win[4] == SIG_B1) &&
               (win[1] == SIG_B4) && (win[0] == SIG_B5) && (din == SIG_B6);
  assign ptr = {win[3], win[2]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < 6; i++) win[i] <= 8'h00;
    end else if (push) begin
      for (int i = 5; i > 0; i--) win[i] <= win[i-1];
      win[0] <= din;
    end
  end
endmodule

// File: rtl/id_override.sv
module id_override #(
  parameter int ADDR_W = 10
) (
  input  logic              en,
  input  logic              half,
  input  logic [ADDR_W-1:0] loc,
  input  logic [15:0]       subst_id,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic [7:0]        rom_rdata,
  output logic [7:0]        cpu_rdata
);
  logic [ADDR_W-1:0] loc_nxt;

  always_comb begin
    loc_nxt = loc + 1'b1;
    if (half) loc_nxt[ADDR_W-1] = 1'b0;
    cpu_rdata = rom_rdata;
    if (en && cpu_rd) begin
      if (cpu_addr == loc)          cpu_rdata = subst_id[15:8];
      else if (cpu_addr == loc_nxt) cpu_rdata = subst_id[7:0];
    end
  end
endmodule

// File: rtl/boot_sig_patcher.sv
module boot_sig_patcher
  import boot_scan_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int WAIT   = 2,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_disable,
  input  logic              size_sel,
  input  logic [15:0]       subst_id,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic [7:0]        rom_rdata,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              cpu_rst,
  output logic [7:0]        cpu_rdata,
  output logic              done,
  output logic              not_found,
  output logic [CNT_W-1:0]  scan_cycles
);
  scan_state_t       state;
  logic              bus_own;
  logic              subst_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] id_loc;
  logic [7:0]        id_hi;
  logic              busy, rd_last, hit;
  logic [15:0]       ptr;
  logic [ADDR_W-1:0] last_addr;

  function automatic logic [ADDR_W-1:0] fold(input logic [15:0] v, input logic half);
    logic [ADDR_W+15:0] t;
    logic [ADDR_W-1:0]  r;
    t = {{ADDR_W{1'b0}}, v};
    r = t[ADDR_W-1:0];
    if (half) r[ADDR_W-1] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a, input logic half);
    logic [ADDR_W-1:0] r;
    r = a + 1'b1;
    if (half) r[ADDR_W-1] = 1'b0;
    return r;
  endfunction

  assign busy      = (state == ST_SCAN) || (state == ST_PTR_HI) || (state == ST_PTR_LO);
  assign last_addr = size_sel ? {ADDR_W{1'b1}} : {1'b0, {(ADDR_W-1){1'b1}}};
  assign rom_addr  = bus_own ? rd_addr : cpu_addr;

  rd_wait_timer #(.WAIT(WAIT)) u_timer (
    .clk(clk), .rst(rst), .busy(busy), .last(rd_last)
  );

  sig_window u_match (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE),
    .push((state == ST_SCAN) && rd_last), .din(rom_rdata),
    .hit(hit), .ptr(ptr)
  );

  id_override #(.ADDR_W(ADDR_W)) u_ovr (
    .en(subst_en && !cpu_rst), .half(!size_sel), .loc(id_loc),
    .subst_id(subst_id), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .rom_rdata(rom_rdata), .cpu_rdata(cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bus_own     <= 1'b1;
      cpu_rst     <= 1'b1;
      done        <= 1'b0;
      not_found   <= 1'b0;
      subst_en    <= 1'b0;
      rd_addr     <= '0;
      id_loc      <= '0;
      id_hi       <= 8'h00;
      scan_cycles <= '0;
    end else begin
      if (busy) scan_cycles <= scan_cycles + 1'b1;
      case (state)
        ST_IDLE: begin
          rd_addr <= '0;
          if (scan_disable) begin
            bus_own <= 1'b0;
            state   <= ST_HANDOFF;
          end else begin
            state <= ST_SCAN;
          end
        end
        ST_SCAN: if (rd_last) begin
          if (hit) begin
            rd_addr <= fold(ptr, !size_sel);
            state   <= ST_PTR_HI;
          end else if (rd_addr == last_addr) begin
            not_found <= 1'b1;
            bus_own   <= 1'b0;
            state     <= ST_HANDOFF;
          end else begin
            rd_addr <= rd_addr + 1'b1;
          end
        end
        ST_PTR_HI: if (rd_last) begin
          id_hi   <= rom_rdata;
          rd_addr <= step(rd_addr, !size_sel);
          state   <= ST_PTR_LO;
        end
        ST_PTR_LO: if (rd_last) begin
          id_loc   <= fold({id_hi, rom_rdata}, !size_sel);
          subst_en <= 1'b1;
          bus_own  <= 1'b0;
          state    <= ST_HANDOFF;
        end
        ST_HANDOFF: begin
          cpu_rst <= 1'b0;
          done    <= 1'b1;
          state   <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  AST_RST_WHILE_READING: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cpu_rst && bus_own)); // R1
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SCAN) && rd_last && !hit && (rd_addr != last_addr))
      |=> (rd_addr == $past(rd_addr) + 1'b1)); // R2
  AST_BUS_BEFORE_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst) |-> $past(!bus_own)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !cpu_rst)); // R6
  AST_MISS_NO_SUB: assert property (@(posedge clk) disable iff (rst)
    not_found |-> !subst_en); // R8
endmodule

// File: tb/tb_boot_sig_patcher.sv
`timescale 1ns/1ps
module tb_boot_sig_patcher;
  localparam int AW = 10;
  localparam int WT = 2;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_disable = 1'b0;
  logic          size_sel = 1'b1;
  logic [15:0]   subst_id = 16'h0000;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0;
  logic [7:0]    rom_rdata;
  logic [AW-1:0] rom_addr;
  logic          cpu_rst, done, not_found;
  logic [7:0]    cpu_rdata;
  logic [CW-1:0] scan_cycles;

  logic [7:0] rom [1024];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign rom_rdata = rom[rom_addr];

  boot_sig_patcher #(.ADDR_W(AW), .WAIT(WT), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .scan_disable(scan_disable), .size_sel(size_sel),
    .subst_id(subst_id), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .rom_rdata(rom_rdata), .rom_addr(rom_addr), .cpu_rst(cpu_rst),
    .cpu_rdata(cpu_rdata), .done(done), .not_found(not_found),
    .scan_cycles(scan_cycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // filler never reaches 0x80, so no signature byte above 0x7F appears by chance
  task automatic fill_rom();
    for (int i = 0; i < 1024; i++) rom[i] = 8'((i * 7 + 3) & 8'h7F);
  endtask

  task automatic put_sig(input int at, input logic [7:0] x, input logic [7:0] y);
    rom[at]   = 8'hEC; rom[at+1] = 8'h9F; rom[at+2] = x; rom[at+3] = y;
    rom[at+4] = 8'h83; rom[at+5] = 8'h12; rom[at+6] = 8'h34;
  endtask

  task automatic boot(input logic dis, input logic sz);
    @(negedge clk);
    rst = 1'b1; scan_disable = dis; size_sel = sz; cpu_rd = 1'b0;
    cpu_addr = 10'h3F0;
    repeat (3) @(negedge clk);
    check("R1 reset cpu_rst", 32'(cpu_rst), 1);
    rst = 1'b0;
    #1;
    check("R1 first addr", 32'(rom_addr), 0);
  endtask

  // waits for done; checks bus handed back one cycle before reset release
  task automatic wait_done();
    int n = 0;
    logic prev_rst = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    while (!done && n < 5000) begin
      prev_rst = cpu_rst; prev_addr = rom_addr;
      @(negedge clk); n++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no done expected done");
    end else begin
      check("R6 bus before reset", {prev_rst, 21'd0, prev_addr}, {1'b1, 21'd0, cpu_addr});
      check("R6 cpu_rst low", 32'(cpu_rst), 0);
    end
  endtask

  task automatic cpu_read(input string req, input int a, input logic rd, input logic [7:0] exp);
    cpu_addr = AW'(a); cpu_rd = rd;
    #1;
    check(req, 32'(cpu_rdata), 32'(exp));
  endtask

  initial begin
    // R9: bypass
    fill_rom(); put_sig(100, 8'h00, 8'hC8); rom[200] = 8'h01; rom[201] = 8'h2C;
    subst_id = 16'hA55A;
    boot(1'b1, 1'b1);
    wait_done();
    check("R9 no reads", 32'(scan_cycles), 0);
    check("R9 not_found low", 32'(not_found), 0);
    cpu_read("R9 no substitution", 300, 1'b1, rom[300]);

    // R3 R5 R7: plain hit at 100, pointer at 200, id location 300
    boot(1'b0, 1'b1);
    wait_done();
    check("R2 R5 read cycles", 32'(scan_cycles), (107 + 2) * (WT + 1));
    check("R3 found", 32'(not_found), 0);
    cpu_read("R7 id high", 300, 1'b1, 8'hA5);
    cpu_read("R7 id low", 301, 1'b1, 8'h5A);
    cpu_read("R7 neighbour", 299, 1'b1, rom[299]);
    cpu_read("R7 no strobe", 300, 1'b0, rom[300]);
    check("R6 done held", 32'(done), 1);

    // R4: broken candidates, the last broken by an EC that starts the real one
    fill_rom();
    rom[380] = 8'hEC; rom[381] = 8'hEC; rom[382] = 8'h9F; rom[383] = 8'h22;
    rom[384] = 8'h33; rom[385] = 8'h83; rom[386] = 8'h12; rom[387] = 8'h35;
    put_sig(400, 8'h05, 8'h06);
    put_sig(406, 8'h00, 8'h64);
    rom[100] = 8'h02; rom[101] = 8'h10;
    subst_id = 16'h1337;
    boot(1'b0, 1'b1);
    wait_done();
    check("R4 read cycles", 32'(scan_cycles), (413 + 2) * (WT + 1));
    check("R4 found", 32'(not_found), 0);
    cpu_read("R4 id high", 16'h210, 1'b1, 8'h13);
    cpu_read("R4 id low", 16'h211, 1'b1, 8'h37);
    cpu_read("R4 first pointer unused", 16'h0506 & 10'h3FF, 1'b1, rom[16'h0506 & 10'h3FF]);

    // R8: no signature, full image
    fill_rom();
    boot(1'b0, 1'b1);
    wait_done();
    check("R8 read cycles", 32'(scan_cycles), 1024 * (WT + 1));
    check("R8 not_found", 32'(not_found), 1);
    cpu_read("R8 pass through", 300, 1'b1, rom[300]);

    // R10: signature only beyond the half image
    fill_rom(); put_sig(600, 8'h00, 8'hC8);
    boot(1'b0, 1'b0);
    wait_done();
    check("R10 half read cycles", 32'(scan_cycles), 512 * (WT + 1));
    check("R10 half not_found", 32'(not_found), 1);

    // R10 R5: half image, pointer and location wrap
    fill_rom(); put_sig(50, 8'h03, 8'h20);
    rom[288] = 8'h04; rom[289] = 8'h80;
    subst_id = 16'hBEEF;
    boot(1'b0, 1'b0);
    wait_done();
    check("R10 half hit cycles", 32'(scan_cycles), (57 + 2) * (WT + 1));
    check("R10 half found", 32'(not_found), 0);
    cpu_read("R5 wrapped id high", 128, 1'b1, 8'hBE);
    cpu_read("R5 wrapped id low", 129, 1'b1, 8'hEF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule